// File: doc/BRIEF.md
# Multifunction Port Pin Bank

This block is a bank of general-purpose pins, eight by default, each of which can be driven from a port data register or from a special-function signal that another block supplies. A direction bit gives each pin one of two drive styles. In the first, the pin is a push-pull output that drives both levels. In the second, the pin is an input that doubles as an open-drain output: it can only pull low, and otherwise it releases the pad.

Software reaches four byte-wide registers through a plain write strobe and a combinational read path. Three of them are the direction, mode and pin-level registers at fixed offsets. The fourth is the data register. The pin-level register always shows the synchronized pad level, whatever the configuration, so a pin that is driving can be read back as it is driving.

The pad itself, any external pull-up and the special-function sources sit outside the block. The block only produces a value and an output enable for each pad and samples each pad's input.

Top module: `mpb_port_bank`

## Requirements
- R1: After reset the direction register reads all ones, the mode register reads 0x00, the data register reads all ones, and no pad output enable is asserted.
- R2: A write with `bus_wr` high at offset 0x1FF3 (direction), 0x1FF1 (mode) or 0x1FF5 (data) loads `bus_wdata` into that register on the clock edge, and a read at the same offset returns it from the next cycle on.
- R3: A pin whose direction bit is 0 has its output enable at 1 and its pad value equal to the selected source bit.
- R4: A pin whose direction bit is 1 has its pad value at 0 and its output enable equal to the inverse of the selected source bit, so it only pulls low.
- R5: A mode bit of 1 makes the pin's special-function input the source. A mode bit of 0 makes the matching data-register bit the source.
- R6: A read at offset 0x1FF7 returns the pad input levels as sampled two clock edges earlier, for every pin, regardless of the direction and mode settings.
- R7: A write at offset 0x1FF7 changes no register and no pad output.
- R8: A read at any offset other than the four listed returns 0x00, and a write there changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_wr | input | 1 | Write strobe for the register interface |
| bus_addr | input | ADDR_W (16) | Register offset for both reads and writes |
| bus_wdata | input | W (8) | Write data |
| bus_rdata | output | W (8) | Read data for `bus_addr`, combinational |
| sf_out | input | W (8) | Special-function value for each pin |
| pad_in | input | W (8) | Level seen at each pad |
| pad_out | output | W (8) | Value driven onto each pad |
| pad_oe | output | W (8) | Output enable for each pad |

## Verification
Direction values of all zeros, all ones and split nibbles are tried, with data and special-function values whose bits differ from each other. This shows whether a fault lies in the push-pull path, the open-drain path or the source select. Pad levels are changed while pins are driving and while they are floating, and the pin register is read one edge and two edges after the change. A stage that is missing or added in the synchronizer therefore shows up, and so does any coupling to the configuration. Writes at the pin offset and at unmapped offsets are each followed by read-back of every register and a look at the pads. A long random phase mixes every offset with changing pad and special-function inputs, and a behavioural model is compared against the block on every cycle.

// File: rtl/mpb_pkg.sv
package mpb_pkg;

  typedef enum logic [2:0] {
    SEL_NONE = 3'd0,
    SEL_DIR  = 3'd1,
    SEL_MODE = 3'd2,
    SEL_DATA = 3'd3,
    SEL_PIN  = 3'd4
  } reg_sel_e;

  // Source for one pin: the special function when the mode bit is set,
  // otherwise the port data bit.
  function automatic logic pick_source(input logic mode_bit,
                                       input logic sf_bit,
                                       input logic data_bit);
    return mode_bit ? sf_bit : data_bit;
  endfunction

  // Pad drive for one pin, returned as {oe, value}.
  // Push-pull (dir=0): always enabled, value follows the source.
  // Open-drain (dir=1): enabled only to pull low.
  function automatic logic [1:0] pad_drive(input logic dir_bit,
                                           input logic src_bit);
    logic oe;
    logic val;
    if (dir_bit) begin
      oe  = ~src_bit;
      val = 1'b0;
    end else begin
      oe  = 1'b1;
      val = src_bit;
    end
    return {oe, val};
  endfunction

endpackage

// File: rtl/mpb_regs.sv
module mpb_regs
  import mpb_pkg::*;
#(
  parameter int              W        = 8,
  parameter int              ADDR_W   = 16,
  parameter logic [ADDR_W-1:0] OFS_DIR  = 16'h1FF3,
  parameter logic [ADDR_W-1:0] OFS_MODE = 16'h1FF1,
  parameter logic [ADDR_W-1:0] OFS_DATA = 16'h1FF5,
  parameter logic [ADDR_W-1:0] OFS_PIN  = 16'h1FF7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [W-1:0]      wdata,
  input  logic [W-1:0]      pin_val,
  output logic [W-1:0]      dir_q,
  output logic [W-1:0]      mode_q,
  output logic [W-1:0]      data_q,
  output logic [W-1:0]      rdata
);

  localparam logic [W-1:0] ALL_ONES  = {W{1'b1}};
  localparam logic [W-1:0] ALL_ZEROS = '0;

  function automatic reg_sel_e decode(input logic [ADDR_W-1:0] a);
    if (a == OFS_DIR)       return SEL_DIR;
    else if (a == OFS_MODE) return SEL_MODE;
    else if (a == OFS_DATA) return SEL_DATA;
    else if (a == OFS_PIN)  return SEL_PIN;
    else                    return SEL_NONE;
  endfunction

  reg_sel_e sel;
  logic     wr_dir;
  logic     wr_mode;
  logic     wr_data;

  assign sel     = decode(addr);
  assign wr_dir  = wr && (sel == SEL_DIR);
  assign wr_mode = wr && (sel == SEL_MODE);
  assign wr_data = wr && (sel == SEL_DATA);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q  <= ALL_ONES;
      mode_q <= ALL_ZEROS;
      data_q <= ALL_ONES;
    end else begin
      if (wr_dir)  dir_q  <= wdata;
      if (wr_mode) mode_q <= wdata;
      if (wr_data) data_q <= wdata;
    end
  end

  always_comb begin
    unique case (sel)
      SEL_DIR:  rdata = dir_q;
      SEL_MODE: rdata = mode_q;
      SEL_DATA: rdata = data_q;
      SEL_PIN:  rdata = pin_val;
      default:  rdata = ALL_ZEROS;
    endcase
  end

endmodule

// File: rtl/mpb_sync.sv
module mpb_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  localparam int LAST = STAGES - 1;

  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg[0] <= '0;
    else        stg[0] <= d;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg[s] <= '0;
      else        stg[s] <= stg[s-1];
    end
  end

  assign q = stg[LAST];

endmodule

// File: rtl/mpb_drive.sv
module mpb_drive
  import mpb_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] dir_q,
  input  logic [W-1:0] mode_q,
  input  logic [W-1:0] data_q,
  input  logic [W-1:0] sf_out,
  output logic [W-1:0] src_vec,
  output logic [W-1:0] pad_out,
  output logic [W-1:0] pad_oe
);

  for (genvar i = 0; i < W; i++) begin : g_pin
    logic [1:0] drv;
    assign src_vec[i] = pick_source(mode_q[i], sf_out[i], data_q[i]);
    assign drv        = pad_drive(dir_q[i], src_vec[i]);
    assign pad_oe[i]  = drv[1];
    assign pad_out[i] = drv[0];
  end

endmodule

// File: rtl/mpb_port_bank.sv
module mpb_port_bank #(
  parameter int              W        = 8,
  parameter int              ADDR_W   = 16,
  parameter int              STAGES   = 2,
  parameter logic [ADDR_W-1:0] OFS_DIR  = 16'h1FF3,
  parameter logic [ADDR_W-1:0] OFS_MODE = 16'h1FF1,
  parameter logic [ADDR_W-1:0] OFS_DATA = 16'h1FF5,
  parameter logic [ADDR_W-1:0] OFS_PIN  = 16'h1FF7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [W-1:0]      bus_wdata,
  output logic [W-1:0]      bus_rdata,
  input  logic [W-1:0]      sf_out,
  input  logic [W-1:0]      pad_in,
  output logic [W-1:0]      pad_out,
  output logic [W-1:0]      pad_oe
);

  // Named internal nets, also observed by the bound checker.
  logic [W-1:0] dir_q;
  logic [W-1:0] mode_q;
  logic [W-1:0] data_q;
  logic [W-1:0] pin_q;
  logic [W-1:0] src_vec;

  mpb_sync #(.W(W), .STAGES(STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (pad_in),
    .q     (pin_q)
  );

  mpb_regs #(
    .W(W), .ADDR_W(ADDR_W),
    .OFS_DIR(OFS_DIR), .OFS_MODE(OFS_MODE),
    .OFS_DATA(OFS_DATA), .OFS_PIN(OFS_PIN)
  ) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr      (bus_wr),
    .addr    (bus_addr),
    .wdata   (bus_wdata),
    .pin_val (pin_q),
    .dir_q   (dir_q),
    .mode_q  (mode_q),
    .data_q  (data_q),
    .rdata   (bus_rdata)
  );

  mpb_drive #(.W(W)) u_drive (
    .dir_q   (dir_q),
    .mode_q  (mode_q),
    .data_q  (data_q),
    .sf_out  (sf_out),
    .src_vec (src_vec),
    .pad_out (pad_out),
    .pad_oe  (pad_oe)
  );

endmodule

// File: rtl/mpb_checker.sv
module mpb_checker #(
  parameter int              W        = 8,
  parameter int              ADDR_W   = 16,
  parameter int              STAGES   = 2,
  parameter logic [ADDR_W-1:0] OFS_DIR  = 16'h1FF3,
  parameter logic [ADDR_W-1:0] OFS_MODE = 16'h1FF1,
  parameter logic [ADDR_W-1:0] OFS_DATA = 16'h1FF5,
  parameter logic [ADDR_W-1:0] OFS_PIN  = 16'h1FF7
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [W-1:0]      bus_wdata,
  input logic [W-1:0]      bus_rdata,
  input logic [W-1:0]      sf_out,
  input logic [W-1:0]      pad_in,
  input logic [W-1:0]      pad_out,
  input logic [W-1:0]      pad_oe,
  input logic [W-1:0]      dir_q,
  input logic [W-1:0]      mode_q,
  input logic [W-1:0]      data_q,
  input logic [W-1:0]      pin_q,
  input logic [W-1:0]      src_vec
);

  logic [1:0] since_rst;
  logic       mapped;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                since_rst <= 2'd0;
    else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
  end

  assign mapped = (bus_addr == OFS_DIR) || (bus_addr == OFS_MODE) ||
                  (bus_addr == OFS_DATA) || (bus_addr == OFS_PIN);

  // R1: reset state seen on the first edge after release
  a_r1_reset_state: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst == 2'd0) |-> (dir_q == {W{1'b1}} && mode_q == '0 &&
                             data_q == {W{1'b1}} && pad_oe == '0));

  // R2: direction write lands on the next edge
  a_r2_dir_write: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == OFS_DIR) |=> (dir_q == $past(bus_wdata)));

  // R3: every push-pull pin is enabled
  a_r3_pushpull_on: assert property (@(posedge clk) disable iff (!rst_n)
    ((~dir_q & ~pad_oe) == '0));

  // R4: open-drain pins never drive high
  a_r4_od_low_only: assert property (@(posedge clk) disable iff (!rst_n)
    ((dir_q & pad_out) == '0));

  // R4: open-drain pins enabled exactly when their source is low
  a_r4_od_enable: assert property (@(posedge clk) disable iff (!rst_n)
    ((dir_q & pad_oe) == (dir_q & ~src_vec)));

  // R5: source follows the mode selection
  a_r5_source_sel: assert property (@(posedge clk) disable iff (!rst_n)
    (src_vec == ((mode_q & sf_out) | (~mode_q & data_q))));

  // R6: pin register lags the pad by two edges
  if (STAGES == 2) begin : g_r6
    a_r6_pin_lag: assert property (@(posedge clk) disable iff (!rst_n)
      (since_rst == 2'd3) |-> (pin_q == $past(pad_in, 2)));
  end

  // R7: writes to the pin offset leave all registers alone
  a_r7_pin_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == OFS_PIN) |=>
      ($stable(dir_q) && $stable(mode_q) && $stable(data_q)));

  // R8: unmapped offsets read as zero
  a_r8_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (!mapped) |-> (bus_rdata == '0));

  // R8: unmapped writes leave all registers alone
  a_r8_unmapped_write: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !mapped) |=>
      ($stable(dir_q) && $stable(mode_q) && $stable(data_q)));

endmodule

bind mpb_port_bank mpb_checker #(
  .W(W), .ADDR_W(ADDR_W), .STAGES(STAGES),
  .OFS_DIR(OFS_DIR), .OFS_MODE(OFS_MODE),
  .OFS_DATA(OFS_DATA), .OFS_PIN(OFS_PIN)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_wr    (bus_wr),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .sf_out    (sf_out),
  .pad_in    (pad_in),
  .pad_out   (pad_out),
  .pad_oe    (pad_oe),
  .dir_q     (dir_q),
  .mode_q    (mode_q),
  .data_q    (data_q),
  .pin_q     (pin_q),
  .src_vec   (src_vec)
);

// File: tb/sim_mpb_port_bank.sv
module sim_mpb_port_bank;

  localparam int CLK_PERIOD = 10;
  localparam logic [15:0] A_DIR  = 16'h1FF3;
  localparam logic [15:0] A_MODE = 16'h1FF1;
  localparam logic [15:0] A_DATA = 16'h1FF5;
  localparam logic [15:0] A_PIN  = 16'h1FF7;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [15:0] bus_addr = 16'h0000;
  logic [7:0]  bus_wdata = 8'h00;
  logic [7:0]  bus_rdata;
  logic [7:0]  sf_out = 8'h00;
  logic [7:0]  pad_in = 8'hA5;
  logic [7:0]  pad_out;
  logic [7:0]  pad_oe;

  int total = 0;
  int bad = 0;
  bit done = 0;

  // Behavioural reference state
  logic [7:0] m_dir = 8'hFF;
  logic [7:0] m_mode = 8'h00;
  logic [7:0] m_data = 8'hFF;
  logic [7:0] pad_hist [$];

  always #(CLK_PERIOD/2) clk = ~clk;

  mpb_port_bank u0 (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sf_out(sf_out),
    .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe)
  );

  always @(posedge clk) begin
    if (!rst_n) begin
      m_dir = 8'hFF; m_mode = 8'h00; m_data = 8'hFF;
      pad_hist.delete();
    end else begin
      if (bus_wr) begin
        if (bus_addr == A_DIR)       m_dir  = bus_wdata;
        else if (bus_addr == A_MODE) m_mode = bus_wdata;
        else if (bus_addr == A_DATA) m_data = bus_wdata;
      end
      pad_hist.push_back(pad_in);
      if (pad_hist.size() > 4) void'(pad_hist.pop_front());
    end
  end

  function automatic logic [7:0] exp_pin();
    if (pad_hist.size() < 2) return 8'h00;
    return pad_hist[pad_hist.size()-2];
  endfunction

  function automatic logic [7:0] exp_read(input logic [15:0] a);
    if (a == A_DIR)  return m_dir;
    if (a == A_MODE) return m_mode;
    if (a == A_DATA) return m_data;
    if (a == A_PIN)  return exp_pin();
    return 8'h00;
  endfunction

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%02h expected=%02h at %0t", tag, act, exp, $time);
    end
  endtask

  // Per-cycle comparison against the model
  always @(negedge clk) begin
    #1;
    if (rst_n && !done) begin
      logic [7:0] e_oe;
      logic [7:0] e_out;
      string rtag;
      for (int i = 0; i < 8; i++) begin
        logic s;
        s = m_mode[i] ? sf_out[i] : m_data[i];
        if (m_dir[i]) begin e_oe[i] = !s; e_out[i] = 1'b0; end
        else          begin e_oe[i] = 1'b1; e_out[i] = s; end
      end
      if (bus_addr == A_PIN) rtag = "R6 pin read";
      else if (bus_addr == A_DIR || bus_addr == A_MODE || bus_addr == A_DATA) rtag = "R2 reg read";
      else rtag = "R8 unmapped read";
      check(rtag, bus_rdata, exp_read(bus_addr));
      check("R3/R4 pad_oe", pad_oe, e_oe);
      check("R3/R4 pad_out", pad_out, e_out);
    end
  end

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input string tag, input logic [15:0] a, input logic [7:0] exp);
    bus_addr = a;
    #2;
    check(tag, bus_rdata, exp);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    bad++; total++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    rd("R1 dir reset", A_DIR, 8'hFF);
    rd("R1 mode reset", A_MODE, 8'h00);
    rd("R1 data reset", A_DATA, 8'hFF);
    check("R1 no drive", pad_oe, 8'h00);

    // R3 push-pull
    wr(A_DIR, 8'h00);
    wr(A_DATA, 8'h3C);
    #2;
    check("R3 oe all", pad_oe, 8'hFF);
    check("R3 out data", pad_out, 8'h3C);
    rd("R2 data readback", A_DATA, 8'h3C);

    // R5 mode select
    sf_out = 8'h96;
    wr(A_MODE, 8'h0F);
    #2;
    check("R5 mixed source", pad_out, 8'h36);
    sf_out = 8'h69;
    #2;
    check("R5 sf follows", pad_out, 8'h39);

    // R4 open-drain
    wr(A_MODE, 8'h00);
    wr(A_DIR, 8'hFF);
    #2;
    check("R4 od oe", pad_oe, 8'hC3);
    check("R4 od out", pad_out, 8'h00);
    wr(A_DIR, 8'hF0);
    #2;
    check("R3/R4 split oe", pad_oe, 8'hCF);
    check("R3/R4 split out", pad_out, 8'h0C);

    // R6 pin register lag
    @(negedge clk);
    pad_in = 8'h5A; bus_addr = A_PIN;
    @(negedge clk);
    rd("R6 one edge still old", A_PIN, 8'hA5);
    @(negedge clk);
    rd("R6 two edges new", A_PIN, 8'h5A);

    // R7 pin writes ignored
    wr(A_PIN, 8'h00);
    rd("R7 dir kept", A_DIR, 8'hF0);
    rd("R7 mode kept", A_MODE, 8'h00);
    rd("R7 data kept", A_DATA, 8'h3C);
    check("R7 pads kept", pad_oe, 8'hCF);

    // R8 unmapped
    rd("R8 zero 1FF0", 16'h1FF0, 8'h00);
    rd("R8 zero 0000", 16'h0000, 8'h00);
    rd("R8 zero 1FF2", 16'h1FF2, 8'h00);
    wr(16'h1FF2, 8'h55);
    rd("R8 dir kept", A_DIR, 8'hF0);
    rd("R8 data kept", A_DATA, 8'h3C);

    // Random phase, compared every cycle by the model
    for (int n = 0; n < 400; n++) begin
      @(negedge clk);
      bus_wr = ($urandom_range(0, 2) == 0);
      case ($urandom_range(0, 5))
        0: bus_addr = A_DIR;
        1: bus_addr = A_MODE;
        2: bus_addr = A_DATA;
        3: bus_addr = A_PIN;
        4: bus_addr = 16'h1FF4;
        default: bus_addr = 16'($urandom);
      endcase
      bus_wdata = 8'($urandom);
      sf_out = 8'($urandom);
      pad_in = 8'($urandom);
    end
    @(negedge clk);
    bus_wr = 1'b0;
    @(negedge clk);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule